// File: doc/BRIEF.md
# I2C Master SCL Period Generator

This block produces the serial clock of an I2C master. It has two pairs of count inputs, one for standard speed and one for fast speed; a speed-select input picks which pair is used. When clocking is enabled, the block drives SCL low for a programmed number of cycles. It then releases SCL and waits until the line is seen high before it times the high phase. A slave that holds SCL low therefore stretches the clock without any extra logic.

Two strobes go to the byte engine that sits beside it. One marks the cycle in the low phase when SDA may change, which is a programmable hold delay after SCL falls. The other marks the midpoint of each high phase, where the received bit should be sampled. START and STOP framing and the byte engine are not part of this block.

The counts, the speed select and the hold delay are captured once, when clocking starts from idle. They stay fixed until the generator returns to idle.

Top module: `scl_period_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, scl_drive_low, sda_update and bit_sample are all 0.
- R2: When run is 1 in an idle cycle, scl_drive_low is 1 from the next cycle onward, for exactly the selected low count plus 1 cycles. Counting begins in the first cycle that SCL is driven low.
- R3: fast_sel = 0 selects the standard-speed pair (ss_hcnt, ss_lcnt); fast_sel = 1 selects the fast-speed pair (fs_hcnt, fs_lcnt).
- R4: After the low phase, SCL is released. The high phase ends after the selected high count plus 8 cycles in which scl_in is sampled 1; cycles in which scl_in is 0 (stretching) lengthen the high phase by the same amount.
- R5: sda_update pulses exactly once in each low phase, in the cycle whose 0-based index from the fall of SCL equals the smaller of sda_hold and the low count.
- R6: bit_sample pulses exactly once in each high phase, in the cycle where scl_in is 1 and (high count + 8)/2 sampled-high cycles (integer division) have already been counted.
- R7: At the end of a high phase, run = 1 starts the next low phase in the very next cycle; run = 0 returns the block to idle with SCL released.
- R8: A change to the count inputs, fast_sel or sda_hold while the generator is running has no effect on the waveform until the next start from idle.
- R9: In idle with run = 0, SCL is not driven and neither strobe pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Enables clocking; sampled in idle and at the end of each high phase |
| fast_sel | input | 1 | Selects the fast-speed count pair when 1 |
| ss_hcnt | input | CW | Standard-speed high count |
| ss_lcnt | input | CW | Standard-speed low count |
| fs_hcnt | input | CW | Fast-speed high count |
| fs_lcnt | input | CW | Fast-speed low count |
| sda_hold | input | HW | Cycles after SCL falls before SDA may change |
| scl_in | input | 1 | Synchronised level of the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_update | output | 1 | One-cycle strobe: SDA may change now |
| bit_sample | output | 1 | One-cycle strobe at the midpoint of the high phase |

## Verification
The bench drives bursts at both speeds, with low counts down to zero and hold values both below and above the low count. A generator that fails to clamp the hold would miss the SDA strobe entirely, and an off-by-one in either offset would show up as a wrong pulse width. A slave stretch in the middle of a burst tests whether the high timer waits for the line; a design that counts from the release would cut the high phase short. The count inputs are changed while a burst is running, so a design that reads them live would produce wrong widths. The bench also drops run at the end of a burst, to catch a design that starts one extra low phase.

// File: rtl/sclgen_pkg.sv
// Shared types and constants for the SCL period generator.
package sclgen_pkg;

    // Generator phase: idle (released), driving low, released and timing high.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_t;

    // Fixed cycle offset added to the programmed high count.
    localparam int HIGH_ADD = 8;

endpackage

// File: rtl/sclgen_cfg_latch.sv
// Captures the selected count pair and the SDA hold on a start from idle.
// From them it derives the comparison limits that the phase logic uses.
// Assumes load is a single-cycle pulse issued only when the generator is idle.
module sclgen_cfg_latch
    import sclgen_pkg::*;
#(
    parameter int CW = 16,
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          fast_sel,
    input  logic [CW-1:0] ss_hcnt,
    input  logic [CW-1:0] ss_lcnt,
    input  logic [CW-1:0] fs_hcnt,
    input  logic [CW-1:0] fs_lcnt,
    input  logic [HW-1:0] sda_hold,
    output logic [CW-1:0] lo_last,
    output logic [CW:0]   hi_last,
    output logic [CW:0]   hi_mid,
    output logic [CW-1:0] sda_at
);
    localparam int MW = (CW > HW) ? CW : HW;

    logic [CW-1:0] sel_hi;
    logic [CW-1:0] sel_lo;
    logic [MW-1:0] hold_x;
    logic [MW-1:0] lo_x;
    logic [CW-1:0] sda_pick;
    logic [CW:0]   hi_ext;

    // Pick the count pair for the requested speed.
    always_comb begin
        sel_hi = fast_sel ? fs_hcnt : ss_hcnt;
        sel_lo = fast_sel ? fs_lcnt : ss_lcnt;
    end

    // Bring hold and low count to a common width for the clamp.
    generate
        if (HW >= CW) begin : g_hold_wide
            assign hold_x = sda_hold;
            assign lo_x   = MW'(sel_lo);
        end else begin : g_hold_narrow
            assign hold_x = MW'(sda_hold);
            assign lo_x   = sel_lo;
        end
    endgenerate

    // Clamp the SDA strobe index to the last low cycle; derive high limits.
    always_comb begin
        sda_pick = (hold_x < lo_x) ? CW'(hold_x) : sel_lo;
        hi_ext   = {1'b0, sel_hi};
    end

    // Hold the derived limits for the whole burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_last <= '0;
            hi_last <= '0;
            hi_mid  <= '0;
            sda_at  <= '0;
        end else if (load) begin
            lo_last <= sel_lo;
            hi_last <= hi_ext + (CW+1)'(HIGH_ADD - 1);
            hi_mid  <= (hi_ext + (CW+1)'(HIGH_ADD)) >> 1;
            sda_at  <= sda_pick;
        end
    end

endmodule

// File: rtl/sclgen_phase.sv
// Phase sequencer and cycle counter. The low phase counts from the first
// driven-low cycle. The high phase counts only cycles with scl_in high, so
// stretching extends it. Assumes scl_in is already synchronised to clk.
module sclgen_phase
    import sclgen_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          scl_in,
    input  logic [CW-1:0] lo_last,
    input  logic [CW:0]   hi_last,
    output phase_t        phase,
    output logic [CW:0]   cnt,
    output logic          load
);
    logic lo_done;
    logic hi_done;

    // Start request and end-of-phase conditions.
    always_comb begin
        load    = (phase == PH_IDLE) && run;
        lo_done = (cnt == {1'b0, lo_last});
        hi_done = scl_in && (cnt == hi_last);
    end

    // Advance phase and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (run) phase <= PH_LOW;
                end
                PH_LOW: begin
                    if (lo_done) begin
                        phase <= PH_HIGH;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (hi_done) begin
                        phase <= run ? PH_LOW : PH_IDLE;
                        cnt   <= '0;
                    end else if (scl_in) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/sclgen_strobes.sv
// Decodes the SCL drive and the two timing strobes from phase and count.
// Assumes the count resets to zero at the start of each phase.
module sclgen_strobes
    import sclgen_pkg::*;
#(
    parameter int CW = 16
) (
    input  phase_t        phase,
    input  logic [CW:0]   cnt,
    input  logic          scl_in,
    input  logic [CW-1:0] sda_at,
    input  logic [CW:0]   hi_mid,
    output logic          scl_drive_low,
    output logic          sda_update,
    output logic          bit_sample
);
    // Output decode.
    always_comb begin
        scl_drive_low = (phase == PH_LOW);
        sda_update    = (phase == PH_LOW) && (cnt == {1'b0, sda_at});
        bit_sample    = (phase == PH_HIGH) && scl_in && (cnt == hi_mid);
    end

endmodule

// File: rtl/scl_period_gen.sv
// Top level of the SCL period generator. Wires the configuration latch, the
// phase sequencer and the strobe decode. Assumes scl_in is synchronised.
module scl_period_gen
    import sclgen_pkg::*;
#(
    parameter int CW = 16,
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          fast_sel,
    input  logic [CW-1:0] ss_hcnt,
    input  logic [CW-1:0] ss_lcnt,
    input  logic [CW-1:0] fs_hcnt,
    input  logic [CW-1:0] fs_lcnt,
    input  logic [HW-1:0] sda_hold,
    input  logic          scl_in,
    output logic          scl_drive_low,
    output logic          sda_update,
    output logic          bit_sample
);
    phase_t        phase;
    logic [CW:0]   cnt;
    logic          load;
    logic [CW-1:0] lo_last;
    logic [CW:0]   hi_last;
    logic [CW:0]   hi_mid;
    logic [CW-1:0] sda_at;

    sclgen_cfg_latch #(.CW(CW), .HW(HW)) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .fast_sel (fast_sel),
        .ss_hcnt  (ss_hcnt),
        .ss_lcnt  (ss_lcnt),
        .fs_hcnt  (fs_hcnt),
        .fs_lcnt  (fs_lcnt),
        .sda_hold (sda_hold),
        .lo_last  (lo_last),
        .hi_last  (hi_last),
        .hi_mid   (hi_mid),
        .sda_at   (sda_at)
    );

    sclgen_phase #(.CW(CW)) phase_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .scl_in  (scl_in),
        .lo_last (lo_last),
        .hi_last (hi_last),
        .phase   (phase),
        .cnt     (cnt),
        .load    (load)
    );

    sclgen_strobes #(.CW(CW)) strobe_i (
        .phase         (phase),
        .cnt           (cnt),
        .scl_in        (scl_in),
        .sda_at        (sda_at),
        .hi_mid        (hi_mid),
        .scl_drive_low (scl_drive_low),
        .sda_update    (sda_update),
        .bit_sample    (bit_sample)
    );

endmodule

// File: rtl/scl_period_gen_chk.sv
// Port-level properties of the SCL period generator, bound to the top.
module scl_period_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic scl_in,
    input logic scl_drive_low,
    input logic sda_update,
    input logic bit_sample
);
    // R5: the SDA strobe only occurs while SCL is driven low.
    a_r5_sda_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        sda_update |-> scl_drive_low);

    // R5: at most one SDA strobe in a row.
    a_r5_sda_single: assert property (@(posedge clk) disable iff (!rst_n)
        sda_update |=> !sda_update);

    // R6: the sample strobe only occurs with SCL released and seen high.
    a_r6_sample_high: assert property (@(posedge clk) disable iff (!rst_n)
        bit_sample |-> (!scl_drive_low && scl_in));

    // R6: at most one sample strobe in a row.
    a_r6_sample_single: assert property (@(posedge clk) disable iff (!rst_n)
        bit_sample |=> !bit_sample);

    // R4: a released, stretched line with run low stays released.
    a_r4_stretch_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_drive_low && !scl_in && !run) |=> !scl_drive_low);

    // R9: never both strobes in the same cycle.
    a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(sda_update && bit_sample));

endmodule

bind scl_period_gen scl_period_gen_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .sda_update    (sda_update),
    .bit_sample    (bit_sample)
);

// File: tb/scl_period_gen_tb_top.sv
// Bench: behavioural reference model compared every cycle, plus pulse-width checks.
module scl_period_gen_tb_top;
    localparam int CW = 16;
    localparam int HW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic          fast_sel = 1'b0;
    logic [CW-1:0] ss_hcnt = '0, ss_lcnt = '0, fs_hcnt = '0, fs_lcnt = '0;
    logic [HW-1:0] sda_hold = '0;
    logic          stretch = 1'b0;
    logic          scl_line;
    logic          scl_drive_low, sda_update, bit_sample;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign scl_line = ~scl_drive_low & ~stretch;

    scl_period_gen #(.CW(CW), .HW(HW)) dut_i (
        .clk(clk), .rst_n(rst_n), .run(run), .fast_sel(fast_sel),
        .ss_hcnt(ss_hcnt), .ss_lcnt(ss_lcnt), .fs_hcnt(fs_hcnt), .fs_lcnt(fs_lcnt),
        .sda_hold(sda_hold), .scl_in(scl_line),
        .scl_drive_low(scl_drive_low), .sda_update(sda_update), .bit_sample(bit_sample)
    );

    // Reference model state.
    int m_ph = 0;
    int m_n = 0;
    int m_l = 0, m_h = 0, m_hold = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0;
            m_n  = 0;
        end else if (m_ph == 0) begin
            if (run) begin
                m_l    = fast_sel ? int'(fs_lcnt) : int'(ss_lcnt);
                m_h    = fast_sel ? int'(fs_hcnt) : int'(ss_hcnt);
                m_hold = int'(sda_hold);
                m_ph   = 1;
                m_n    = 0;
            end
        end else if (m_ph == 1) begin
            if (m_n == m_l) begin m_ph = 2; m_n = 0; end
            else m_n++;
        end else begin
            if (scl_line) begin
                if (m_n == m_h + 7) begin m_ph = run ? 1 : 0; m_n = 0; end
                else m_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Pulse-width monitor and stretch injection.
    int lo_q[$];
    int hi_q[$];
    int run_len = 0;
    bit prev_low = 0;
    bit seen_low = 0;
    int low_count = 0;
    int fall_count = 0;
    int stretch_on = -1;
    int stretch_len = 0;
    int stretch_left = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            // Per-cycle comparison with the model.
            chk(scl_drive_low == (m_ph == 1), "R2/R4 scl_drive_low", scl_drive_low, m_ph == 1);
            chk(sda_update == (m_ph == 1 && m_n == ((m_hold < m_l) ? m_hold : m_l)),
                "R5 sda_update", sda_update, m_ph == 1 && m_n == ((m_hold < m_l) ? m_hold : m_l));
            chk(bit_sample == (m_ph == 2 && scl_line && m_n == (m_h + 8) / 2),
                "R6 bit_sample", bit_sample, m_ph == 2 && scl_line && m_n == (m_h + 8) / 2);
        end
        // Width bookkeeping.
        if (scl_drive_low != prev_low) begin
            if (prev_low) begin
                lo_q.push_back(run_len);
                fall_count++;
                seen_low = 1;
                if (fall_count == stretch_on) stretch_left = stretch_len;
            end else begin
                if (seen_low) hi_q.push_back(run_len);
                low_count++;
            end
            run_len = 1;
        end else begin
            run_len++;
        end
        prev_low = scl_drive_low;
        stretch = (stretch_left > 0);
        if (stretch_left > 0) stretch_left--;
    end

    task automatic clear_mon();
        lo_q.delete();
        hi_q.delete();
        seen_low   = 0;
        low_count  = 0;
        fall_count = 0;
        stretch_on = -1;
    endtask

    // Runs a burst of n low phases, then lets the generator go idle.
    task automatic burst(input int n);
        run = 1'b1;
        while (fall_count < n) @(negedge clk);
        run = 1'b0;
        repeat (60) @(negedge clk);
    endtask

    initial begin : main
        // R1: reset state.
        repeat (3) @(negedge clk);
        chk(!scl_drive_low && !sda_update && !bit_sample, "R1 outputs in reset",
            {scl_drive_low, sda_update, bit_sample}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!scl_drive_low && !sda_update && !bit_sample, "R1 outputs after reset",
            {scl_drive_low, sda_update, bit_sample}, 0);

        // R9: idle with run low.
        ss_hcnt = 2; ss_lcnt = 3; sda_hold = 1;
        fs_hcnt = 0; fs_lcnt = 5;
        repeat (10) @(negedge clk);
        chk(!scl_drive_low && !sda_update && !bit_sample, "R9 idle quiet",
            {scl_drive_low, sda_update, bit_sample}, 0);

        // R2 R3 R4 R7: standard-speed burst of 3 bits.
        clear_mon();
        burst(3);
        chk(lo_q.size() == 3, "R7 standard low count", lo_q.size(), 3);
        foreach (lo_q[i]) chk(lo_q[i] == 4, "R2 standard low width", lo_q[i], 4);
        chk(hi_q.size() == 2, "R7 standard high count", hi_q.size(), 2);
        foreach (hi_q[i]) chk(hi_q[i] == 10, "R4 standard high width", hi_q[i], 10);
        chk(!scl_drive_low, "R7 idle after burst", scl_drive_low, 0);

        // R3 R4 R5: fast speed, hold clamped, stretch of 3 in second high.
        clear_mon();
        fast_sel = 1'b1; sda_hold = 9;
        stretch_on = 2; stretch_len = 3;
        burst(3);
        foreach (lo_q[i]) chk(lo_q[i] == 6, "R3 fast low width", lo_q[i], 6);
        chk(hi_q.size() == 2, "R4 fast high count", hi_q.size(), 2);
        if (hi_q.size() == 2) begin
            chk(hi_q[0] == 8, "R4 fast high width", hi_q[0], 8);
            chk(hi_q[1] == 11, "R4 stretched high width", hi_q[1], 11);
        end

        // R8: change counts while running.
        clear_mon();
        fast_sel = 1'b0; ss_lcnt = 2; ss_hcnt = 1; sda_hold = 0;
        run = 1'b1;
        while (fall_count < 1) @(negedge clk);
        ss_lcnt = 20; ss_hcnt = 30; sda_hold = 7; fast_sel = 1'b1;
        while (fall_count < 3) @(negedge clk);
        run = 1'b0;
        repeat (60) @(negedge clk);
        foreach (lo_q[i]) chk(lo_q[i] == 3, "R8 low width unchanged", lo_q[i], 3);
        foreach (hi_q[i]) chk(hi_q[i] == 9, "R8 high width unchanged", hi_q[i], 9);

        // R8: new values apply on the next start (fast pair now selected).
        clear_mon();
        fs_lcnt = 0; fs_hcnt = 3; sda_hold = 0;
        burst(2);
        foreach (lo_q[i]) chk(lo_q[i] == 1, "R8 R2 new low width", lo_q[i], 1);
        foreach (hi_q[i]) chk(hi_q[i] == 11, "R8 new high width", hi_q[i], 11);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog actual=hung expected=idle");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule